// File: doc/BRIEF.md
# Multi-Channel Sticky Status Latch Bank

This block holds the sticky status bits for eight identical line channels. Each channel has two groups of latches. The event group captures single-cycle event pulses, such as packet-engine events. The transition group watches slow live status levels and latches on their edges. One live bit latches only on a rising edge. Another latches on any change. A host reads the latches through a simple synchronous port. A read returns the captured value and clears what it read. Each channel also drives its own interrupt-pending line.

The 12-bit address splits into two fields. Bits 11:8 select the channel and bits 7:0 select the register within the channel. Each channel has three registers:

- Offset 0x10 is the event latch register.
- Offset 0x11 is the transition latch register.
- Offset 0x12 is the interrupt status register. It shows one summary bit per latch group.

Reading the interrupt status register also clears the transition latches. The event latches are cleared only through their own register.

Top module: `lsr_bank`

## Requirements
- R1: There are eight channels. Address bits 11:8 pick channel 0 to 7. A read with a channel field of 8 to 15 returns zero and clears nothing.
- R2: During and after reset, every latch is zero, irq_o is zero and rdata_o is zero.
- R3: Bit k of offset 0x10 is set in the cycle after evt_i[ch*9+k] is high. It stays set until offset 0x10 of that channel is read. A read of offset 0x12 leaves it unchanged.
- R4: Bit 0 of offset 0x11 is set after a 0-to-1 change of live_i[ch*2]. A 1-to-0 change does not set it.
- R5: Bit 1 of offset 0x11 is set after any change, rising or falling, of live_i[ch*2+1].
- R6: A read of offset 0x11 or offset 0x12 of a channel clears that channel's offset 0x11 latches.
- R7: Offset 0x12 reads as follows. Bit 0 is the OR of the channel's event latches. Bit 1 is the OR of its transition latches.
- R8: rdata_o carries the register value as it was before any clear. It appears in the cycle after rd_i is high. rdata_o is zero in any cycle that does not follow a read.
- R9: If a latch's set condition occurs in the same cycle as a read that clears it, the latch ends up set.
- R10: irq_o[ch] is high while any latch of channel ch is set.
- R11: Bits 15:9 of every read, and all offsets other than 0x10 to 0x12, read zero. Writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe (no effect) |
| addr_i | input | 12 | Host address: channel in bits 11:8, offset in bits 7:0 |
| wdata_i | input | 16 | Host write data (no effect) |
| rdata_o | output | 16 | Read data, valid in the cycle after rd_i |
| evt_i | input | 72 | Event pulses, 9 per channel, bit ch*9+k |
| live_i | input | 16 | Live status, 2 per channel, bit ch*2+j |
| irq_o | output | 8 | Per-channel interrupt pending |

## Verification
The assertions check on every cycle that:
- a rising edge of live bit 0 and any change of live bit 1 are captured;
- an event pulse always leaves the channel's interrupt line high in the next cycle, even when a clearing read collides with it;
- idle cycles return zero read data;
- the unused upper bits stay zero.

Only the bench's scenarios can show the rest, by comparing reads against a behavioural model and directed expected values. These cover:
- which read clears which group;
- that the data returned is the value before the clear;
- that out-of-range channels and writes leave the latches untouched;
- that a falling edge on the rising-only bit sets nothing.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int unsigned NUM_CH = 8;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned OFF_W  = 8;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned N_EVT  = 9;
  localparam int unsigned N_LIVE = 2;
  // 1 = latch on any edge, 0 = rising edge only
  localparam logic [N_LIVE-1:0] ANY_EDGE_MASK = 2'b10;

  localparam logic [OFF_W-1:0] OFF_EVT = 8'h10;
  localparam logic [OFF_W-1:0] OFF_TRN = 8'h11;
  localparam logic [OFF_W-1:0] OFF_ISR = 8'h12;
endpackage

// File: rtl/lsr_edge_det.sv
module lsr_edge_det #(
  parameter int unsigned   N        = 2,
  parameter logic [N-1:0]  ANY_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] live_i,
  output logic [N-1:0] hit_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= live_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (ANY_MASK[i]) begin : g_any
      assign hit_o[i] = live_i[i] ^ prev_q[i];
    end else begin : g_rise
      assign hit_o[i] = live_i[i] & ~prev_q[i];
    end
  end
endmodule

// File: rtl/lsr_latch.sv
module lsr_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q & ~{W{clr_i}}) | set_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/lsr_channel.sv
module lsr_channel #(
  parameter int unsigned        N_EVT    = 9,
  parameter int unsigned        N_LIVE   = 2,
  parameter logic [N_LIVE-1:0]  ANY_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [N_LIVE-1:0] live_i,
  input  logic              clr_evt_i,
  input  logic              clr_trn_i,
  output logic [N_EVT-1:0]  evt_lat_o,
  output logic [N_LIVE-1:0] trn_lat_o,
  output logic              irq_o
);
  logic [N_LIVE-1:0] hit;

  lsr_edge_det #(.N(N_LIVE), .ANY_MASK(ANY_MASK)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .live_i (live_i),
    .hit_o  (hit)
  );

  lsr_latch #(.W(N_EVT)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_i),
    .clr_i  (clr_evt_i),
    .q_o    (evt_lat_o)
  );

  lsr_latch #(.W(N_LIVE)) u_trn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (clr_trn_i),
    .q_o    (trn_lat_o)
  );

  assign irq_o = (|evt_lat_o) | (|trn_lat_o);
endmodule

// File: rtl/lsr_bank.sv
module lsr_bank
  import lsr_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  input  logic [NCH*N_EVT-1:0]   evt_i,
  input  logic [NCH*N_LIVE-1:0]  live_i,
  output logic [NCH-1:0]         irq_o
);
  localparam int unsigned CH_W  = ADDR_W - OFF_W;
  localparam int unsigned SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CH_W-1:0]  ch_fld;
  logic [OFF_W-1:0] off_fld;
  logic             ch_ok;
  logic [SEL_W-1:0] sel;

  assign ch_fld  = addr_i[ADDR_W-1:OFF_W];
  assign off_fld = addr_i[OFF_W-1:0];
  assign ch_ok   = ch_fld < CH_W'(NCH);
  assign sel     = ch_fld[SEL_W-1:0];

  logic [N_EVT-1:0]  evt_lat [NCH];
  logic [N_LIVE-1:0] trn_lat [NCH];
  logic [NCH*N_LIVE-1:0] trn_lat_flat;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit_ch;
    assign hit_ch = rd_i && ch_ok && (ch_fld == CH_W'(c));

    lsr_channel #(.N_EVT(N_EVT), .N_LIVE(N_LIVE), .ANY_MASK(ANY_EDGE_MASK)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i[c*N_EVT +: N_EVT]),
      .live_i    (live_i[c*N_LIVE +: N_LIVE]),
      .clr_evt_i (hit_ch && (off_fld == OFF_EVT)),
      .clr_trn_i (hit_ch && ((off_fld == OFF_TRN) || (off_fld == OFF_ISR))),
      .evt_lat_o (evt_lat[c]),
      .trn_lat_o (trn_lat[c]),
      .irq_o     (irq_o[c])
    );
    assign trn_lat_flat[c*N_LIVE +: N_LIVE] = trn_lat[c];
  end

  logic [DATA_W-1:0] rdata_d, rdata_q;

  always_comb begin
    rdata_d = '0;
    if (rd_i && ch_ok) begin
      case (off_fld)
        OFF_EVT: rdata_d[N_EVT-1:0]  = evt_lat[sel];
        OFF_TRN: rdata_d[N_LIVE-1:0] = trn_lat[sel];
        OFF_ISR: rdata_d[1:0]        = {|trn_lat[sel], |evt_lat[sel]};
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // latches are read-only; host writes are accepted and dropped
  logic unused_wr;
  assign unused_wr = ^{wr_i, wdata_i};
endmodule

// File: rtl/lsr_bank_chk.sv
module lsr_bank_chk
  import lsr_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  rd_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic [NCH*N_EVT-1:0]  evt_i,
  input logic [NCH*N_LIVE-1:0] live_i,
  input logic [NCH*N_LIVE-1:0] trn_lat_flat,
  input logic [NCH-1:0]        irq_o
);
  // R2
  rst_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0 && rdata_o == '0));

  // R8
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == '0);

  // R11
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:N_EVT] == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R9 R10
    evt_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|evt_i[c*N_EVT +: N_EVT]) |=> irq_o[c]);

    for (genvar b = 0; b < N_LIVE; b++) begin : g_bit
      if (ANY_EDGE_MASK[b]) begin : g_any
        // R5
        any_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          !$stable(live_i[c*N_LIVE+b]) |=> trn_lat_flat[c*N_LIVE+b]);
      end else begin : g_rise
        // R4
        rise_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          $rose(live_i[c*N_LIVE+b]) |=> trn_lat_flat[c*N_LIVE+b]);
      end
    end
  end
endmodule

bind lsr_bank lsr_bank_chk #(.NCH(NCH)) u_lsr_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_i         (rd_i),
  .rdata_o      (rdata_o),
  .evt_i        (evt_i),
  .live_i       (live_i),
  .trn_lat_flat (trn_lat_flat),
  .irq_o        (irq_o)
);

// File: tb/lsr_bank_tb_top.sv
module lsr_bank_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NCH = 8;
  localparam int  NE  = 9;
  localparam int  NL  = 2;

  logic              clk_i = 0;
  logic              rst_ni = 0;
  logic              rd_i = 0, wr_i = 0;
  logic [11:0]       addr_i = '0;
  logic [15:0]       wdata_i = '0;
  logic [15:0]       rdata_o;
  logic [NCH*NE-1:0] evt_i = '0;
  logic [NCH*NL-1:0] live_i = '0;
  logic [NCH-1:0]    irq_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lsr_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .evt_i(evt_i), .live_i(live_i), .irq_o(irq_o)
  );

  // behavioural reference
  int unsigned m_evt [NCH];
  int unsigned m_trn [NCH];
  int unsigned m_prev[NCH];
  int unsigned m_rd;

  always @(posedge clk_i) begin
    int unsigned ch, off, e, l, hit;
    if (!rst_ni) begin
      foreach (m_evt[i]) begin m_evt[i] = 0; m_trn[i] = 0; m_prev[i] = 0; end
      m_rd = 0;
    end else begin
      ch = addr_i / 256; off = addr_i % 256;
      m_rd = 0;
      if (rd_i && ch < NCH) begin
        if (off == 16) m_rd = m_evt[ch];
        else if (off == 17) m_rd = m_trn[ch];
        else if (off == 18) m_rd = ((m_trn[ch] != 0) ? 2 : 0) + ((m_evt[ch] != 0) ? 1 : 0);
        if (off == 16) m_evt[ch] = 0;
        if (off == 17 || off == 18) m_trn[ch] = 0;
      end
      for (int c = 0; c < NCH; c++) begin
        e = (evt_i >> (c*NE)) & 9'h1FF;
        l = (live_i >> (c*NL)) & 2'h3;
        hit = 0;
        if ((l & 1) && !(m_prev[c] & 1)) hit += 1;       // rising only
        if (((l >> 1) & 1) != ((m_prev[c] >> 1) & 1)) hit += 2; // any edge
        m_evt[c] |= e;
        m_trn[c] |= hit;
        m_prev[c] = l;
      end
    end
  end

  function automatic logic [7:0] m_irq();
    logic [7:0] r;
    for (int c = 0; c < NCH; c++) r[c] = (m_evt[c] != 0) || (m_trn[c] != 0);
    return r;
  endfunction

  always @(negedge clk_i) if (rst_ni && !done) begin
    n_chk++;
    if (rdata_o !== 16'(m_rd)) begin
      n_bad++;
      $display("FAIL R8 rdata_o act=%h exp=%h", rdata_o, 16'(m_rd));
    end
    n_chk++;
    if (irq_o !== m_irq()) begin
      n_bad++;
      $display("FAIL R10 irq_o act=%h exp=%h", irq_o, m_irq());
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk_i); rd_i = 1; addr_i = a;
    @(negedge clk_i); chk(tag, rdata_o, exp); rd_i = 0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk_i); evt_i[idx] = 1;
    @(negedge clk_i); evt_i[idx] = 0;
  endtask

  task automatic set_live(input int idx, input logic v);
    @(negedge clk_i); live_i[idx] = v;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R2 irq in reset", {8'h0, irq_o}, 16'h0);
    chk("R2 rdata in reset", rdata_o, 16'h0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    chk("R2 irq after reset", {8'h0, irq_o}, 16'h0);
    // R3 event latch and own-read clear
    pulse(2*NE + 3);
    rd_chk(12'h210, 16'h0008, "R3 evt ch2");
    rd_chk(12'h210, 16'h0000, "R3 evt ch2 cleared");
    // R7 summary, R3 not cleared by summary read
    pulse(5*NE + 8);
    rd_chk(12'h512, 16'h0001, "R7 isr ch5");
    rd_chk(12'h510, 16'h0100, "R3 evt ch5 kept");
    // R4 rising only
    set_live(1*NL + 0, 1);
    rd_chk(12'h111, 16'h0001, "R4 rise ch1");
    set_live(1*NL + 0, 0);
    rd_chk(12'h111, 16'h0000, "R4 fall ignored");
    // R5 any edge
    set_live(1*NL + 1, 1);
    rd_chk(12'h111, 16'h0002, "R5 rise ch1");
    set_live(1*NL + 1, 0);
    rd_chk(12'h111, 16'h0002, "R5 fall ch1");
    // R6 summary read clears transitions
    set_live(3*NL + 1, 1);
    rd_chk(12'h312, 16'h0002, "R7 isr ch3");
    rd_chk(12'h311, 16'h0000, "R6 trn cleared by isr");
    // R9 event during clearing read
    pulse(4*NE + 1);
    @(negedge clk_i); rd_i = 1; addr_i = 12'h410; evt_i[4*NE + 0] = 1;
    @(negedge clk_i); chk("R9 pre-clear value", rdata_o, 16'h0002);
    rd_i = 0; evt_i[4*NE + 0] = 0;
    rd_chk(12'h410, 16'h0001, "R9 event kept");
    // R10 irq
    pulse(6*NE + 0);
    chk("R10 irq ch6", {8'h0, irq_o}, 16'h0040);
    rd_chk(12'h610, 16'h0001, "R10 read ch6");
    chk("R10 irq clear", {8'h0, irq_o}, 16'h0000);
    // R1 out-of-range channel
    pulse(0*NE + 5);
    rd_chk(12'h910, 16'h0000, "R1 ch9 reads zero");
    chk("R1 ch0 irq kept", {15'h0, irq_o[0]}, 16'h0001);
    rd_chk(12'h010, 16'h0020, "R1 ch0 not cleared");
    // R11 writes and unmapped offsets
    @(negedge clk_i); wr_i = 1; addr_i = 12'h010; wdata_i = 16'hFFFF;
    @(negedge clk_i); wr_i = 0;
    rd_chk(12'h010, 16'h0000, "R11 write no set");
    pulse(7*NE + 2);
    @(negedge clk_i); wr_i = 1; addr_i = 12'h710; wdata_i = 16'h0000;
    @(negedge clk_i); wr_i = 0;
    rd_chk(12'h710, 16'h0004, "R11 write no clear");
    pulse(7*NE + 8);
    rd_chk(12'h720, 16'h0000, "R11 unmapped offset");
    rd_chk(12'h710, 16'h0100, "R11 unmapped no clear");
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule